// File: doc/BRIEF.md
# Paired-Sample Width-Converting FIFO

This block is a single-clock queue that takes in words holding two packed ADC samples and hands them out one sample per clock. Each write word carries the sample taken on the rising edge of the converter clock in its low half and the sample taken on the falling edge in its high half. Both halves go into one storage array as one entry. The two sample streams therefore share a single write pointer and a single read pointer, and they cannot drift out of step the way two separate queues could.

The write side is a plain enable with `full` and a sticky `overflow` flag. A write presented while `full` is high is dropped and recorded. The read side is a valid/ready stream. `rd_valid` stays high for as long as at least one sample is held. A sample is consumed on a rising edge where `rd_valid` and `rd_ready` are both high. While `rd_ready` is low, the presented sample and `rd_valid` hold unchanged, so the consumer can stall for any number of cycles. Each stored word drains over two accepted reads, low half first. The read side moves one sample per clock, so sustained input must stay at or below one word every two cycles on average.

Top module: `pair_unpack_fifo`

## Requirements
- R1: After a synchronous active-high reset, `empty` is 1, `rd_valid` is 0, `full` is 0 and `overflow` is 0.
- R2: A write with `wr_en` high while `full` is low stores the word, and `rd_valid` is high from the next clock edge onward.
- R3: Samples leave in capture order. First comes bits 11:0 of a word, then bits 23:12 of the same word, then the next word in write order. No sample is lost or repeated.
- R4: While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_valid` keep their values at the next edge (back-pressure).
- R5: A stored word keeps its slot until its high half has been consumed. A word whose low half has already been read still counts toward `full`.
- R6: `full` is high when DEPTH words are held. A write while `full` is high is discarded, even if a read happens in the same cycle. The discarded write sets `overflow`, which stays at 1 until reset.
- R7: `empty` is the inverse of `rd_valid` and counts single samples. A word with only its high half left reports `rd_valid`=1 and `empty`=0.
- R8: `rd_ready` while `empty` is high has no effect. No sample appears, and the next written word is read starting with its low half.
- R9: A reset asserted while data is held discards all of it and clears `overflow`.
- R10: Writes on every second cycle with `rd_ready` held high never raise `full` or `overflow`, and every sample is delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request for `wr_data` |
| wr_data | input | 24 | Two samples: rising-edge sample in 11:0, falling-edge sample in 23:12 |
| full | output | 1 | DEPTH words held; writes are discarded |
| overflow | output | 1 | Sticky: a write was discarded since reset |
| rd_data | output | 12 | Sample presented to the consumer |
| rd_valid | output | 1 | `rd_data` holds a sample |
| rd_ready | input | 1 | Consumer accepts `rd_data` at this edge |
| empty | output | 1 | No sample held |

## Verification
The hardest state to reach from the ports is a full queue whose oldest word is half consumed, with a write arriving in the same cycle as a read. That is the one point where a slot-freeing rule or a full test based on the wrong state would either drop a valid word or accept one it should reject. The bench fills the queue with the consumer stalled and reads one low half. It then pushes a write together with a read of the high half. A reference queue of single samples predicts which words survive. After that, long random runs with random stalls keep returning the queue to the full boundary with a half-read head word.

// File: rtl/pair_unpack_pkg.sv
package pair_unpack_pkg;

  // Which half of the head word is presented to the consumer.
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;

  localparam int unsigned SAMPLES_PER_WORD = 2;

endpackage

// File: rtl/pu_wr_ctrl.sv
module pu_wr_ctrl #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          full,
  output logic          wr_accept,
  output logic [AW:0]   wptr,
  output logic          overflow
);

  logic [AW:0] wptr_q;
  logic        ovf_q;

  assign wr_accept = wr_en & ~full;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
    end else if (wr_accept) begin
      wptr_q <= wptr_q + 1'b1;
    end
  end

  // Sticky record of any write refused because the store was full.
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= 1'b0;
    end else if (wr_en && full) begin
      ovf_q <= 1'b1;
    end
  end

  assign wptr     = wptr_q;
  assign overflow = ovf_q;

endmodule

// File: rtl/pu_rd_ctrl.sv
module pu_rd_ctrl
  import pair_unpack_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_valid,
  input  logic        rd_ready,
  output logic [AW:0] rptr,
  output half_sel_e   half
);

  logic [AW:0] rptr_q;
  half_sel_e   half_q;
  logic        take;

  assign take = rd_valid & rd_ready;

  // Half select flips on every consumed sample.
  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= HALF_LO;
    end else if (take) begin
      half_q <= (half_q == HALF_LO) ? HALF_HI : HALF_LO;
    end
  end

  // The slot is released only once its upper sample is gone.
  always_ff @(posedge clk) begin
    if (rst) begin
      rptr_q <= '0;
    end else if (take && (half_q == HALF_HI)) begin
      rptr_q <= rptr_q + 1'b1;
    end
  end

  assign rptr = rptr_q;
  assign half = half_q;

endmodule

// File: rtl/pu_flags.sv
module pu_flags #(
  parameter int unsigned AW = 4
) (
  input  logic [AW:0] wptr,
  input  logic [AW:0] rptr,
  output logic        full,
  output logic        word_empty
);

  logic          same_idx;
  logic          wrap_diff;

  assign same_idx   = (wptr[AW-1:0] == rptr[AW-1:0]);
  assign wrap_diff  = wptr[AW] ^ rptr[AW];
  assign full       = same_idx & wrap_diff;
  assign word_empty = same_idx & ~wrap_diff;

endmodule

// File: rtl/pu_store.sv
module pu_store
  import pair_unpack_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned SAMPLE_W = 12,
  localparam int unsigned AW      = $clog2(DEPTH),
  localparam int unsigned WORD_W  = SAMPLE_W * SAMPLES_PER_WORD
) (
  input  logic                clk,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [WORD_W-1:0]   wdata,
  input  logic [AW-1:0]       raddr,
  input  half_sel_e           half,
  output logic [SAMPLE_W-1:0] sample
);

  logic [WORD_W-1:0]   mem [DEPTH];
  logic [WORD_W-1:0]   head;
  logic [SAMPLE_W-1:0] lane [SAMPLES_PER_WORD];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Show-ahead read: the head word is always on the output.
  assign head = mem[raddr];

  for (genvar g = 0; g < SAMPLES_PER_WORD; g++) begin : g_lane
    assign lane[g] = head[g*SAMPLE_W +: SAMPLE_W];
  end

  assign sample = lane[half];

endmodule

// File: rtl/pair_unpack_fifo.sv
module pair_unpack_fifo
  import pair_unpack_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned SAMPLE_W = 12,
  localparam int unsigned AW      = $clog2(DEPTH),
  localparam int unsigned WORD_W  = SAMPLE_W * SAMPLES_PER_WORD
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [WORD_W-1:0]   wr_data,
  output logic                full,
  output logic                overflow,
  output logic [SAMPLE_W-1:0] rd_data,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic                empty
);

  logic [AW:0] wptr;
  logic [AW:0] rptr;
  logic        wr_accept;
  logic        word_empty;
  half_sel_e   half;

  pu_wr_ctrl #(.AW(AW)) u_wr (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .full      (full),
    .wr_accept (wr_accept),
    .wptr      (wptr),
    .overflow  (overflow)
  );

  pu_rd_ctrl #(.AW(AW)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rptr     (rptr),
    .half     (half)
  );

  pu_flags #(.AW(AW)) u_flags (
    .wptr       (wptr),
    .rptr       (rptr),
    .full       (full),
    .word_empty (word_empty)
  );

  pu_store #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W)) u_store (
    .clk    (clk),
    .we     (wr_accept),
    .waddr  (wptr[AW-1:0]),
    .wdata  (wr_data),
    .raddr  (rptr[AW-1:0]),
    .half   (half),
    .sample (rd_data)
  );

  // A half-read word keeps the pointers apart, so this counts samples.
  assign rd_valid = ~word_empty;
  assign empty    = word_empty;

endmodule

// File: rtl/pair_unpack_fifo_chk.sv
module pair_unpack_fifo_chk #(
  parameter int unsigned SAMPLE_W = 12,
  localparam int unsigned WORD_W  = SAMPLE_W * 2
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [WORD_W-1:0]   wr_data,
  input logic                full,
  input logic                overflow,
  input logic [SAMPLE_W-1:0] rd_data,
  input logic                rd_valid,
  input logic                rd_ready,
  input logic                empty
);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (empty && !rd_valid && !full && !overflow)); // R1

  AST_WRITE_SHOWS: assert property (@(posedge clk) disable iff (rst) (wr_en && !full) |=> rd_valid); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst) (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R4

  AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (rst) (full && !(rd_valid && rd_ready)) |=> full); // R5

  AST_OVF_SETS: assert property (@(posedge clk) disable iff (rst) (wr_en && full) |=> overflow); // R6

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) overflow |=> overflow); // R6

  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst) !(full && empty)); // R7

endmodule

bind pair_unpack_fifo pair_unpack_fifo_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .full     (full),
  .overflow (overflow),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .empty    (empty)
);

// File: tb/pair_unpack_fifo_tb.sv
`timescale 1ns/1ps
module pair_unpack_fifo_tb;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [23:0] wr_data = '0;
  logic        rd_ready = 1'b0;
  logic        full, overflow, rd_valid, empty;
  logic [11:0] rd_data;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [11:0] q[$];
  bit          movf;

  always #2.5 clk = ~clk;

  pair_unpack_fifo #(.DEPTH(DEPTH), .SAMPLE_W(12)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .overflow(overflow), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .empty(empty)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int held_words();
    return (q.size() + 1) / 2;
  endfunction

  // Compare outputs with the model, drive one cycle, advance the model.
  task automatic step(input logic we, input logic [23:0] wd, input logic rdy);
    bit ev = (q.size() != 0);
    bit ef = (held_words() == DEPTH);
    chk(rd_valid === ev, "R2 rd_valid", rd_valid, ev);
    chk(empty === !ev, "R7 empty", empty, !ev);
    chk(full === ef, "R6 full", full, ef);
    chk(overflow === movf, "R6 overflow", overflow, movf);
    if (ev) chk(rd_data === q[0], "R3 rd_data order", rd_data, q[0]);
    wr_en = we; wr_data = wd; rd_ready = rdy;
    if (rdy && ev) void'(q.pop_front());
    if (we) begin
      if (ef) movf = 1;
      else begin q.push_back(wd[11:0]); q.push_back(wd[23:12]); end
    end
    @(posedge clk); @(negedge clk);
    wr_en = 0; rd_ready = 0;
  endtask

  task automatic do_reset();
    rst = 1; wr_en = 0; rd_ready = 0;
    @(posedge clk); @(negedge clk);
    rst = 0;
    q.delete(); movf = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C1A));
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(empty === 1, "R1 empty", empty, 1);
    chk(rd_valid === 0, "R1 rd_valid", rd_valid, 0);
    chk(full === 0, "R1 full", full, 0);
    chk(overflow === 0, "R1 overflow", overflow, 0);

    // R8 read strobes on an empty queue
    for (int i = 0; i < 4; i++) step(0, '0, 1);
    chk(empty === 1, "R8 empty after idle reads", empty, 1);

    // R2/R3/R4/R7 one word, stall, then halves
    step(1, 24'hABC123, 0);
    chk(rd_valid === 1, "R2 valid after write", rd_valid, 1);
    chk(rd_data === 12'h123, "R8 low half first after idle reads", rd_data, 12'h123);
    step(0, '0, 0);
    step(0, '0, 0);
    chk(rd_data === 12'h123, "R4 hold under stall", rd_data, 12'h123);
    step(0, '0, 1);
    chk(rd_data === 12'hABC, "R3 high half second", rd_data, 12'hABC);
    chk(rd_valid === 1 && empty === 0, "R7 half word still valid", {empty, rd_valid}, 2'b01);
    step(0, '0, 1);
    chk(empty === 1, "R3 drained after two reads", empty, 1);

    // R5/R6 fill, overflow, half-read head still counts
    for (int i = 0; i < DEPTH; i++) step(1, {12'h800 + 12'(i), 12'h100 + 12'(i)}, 0);
    chk(full === 1, "R6 full at DEPTH", full, 1);
    step(1, 24'hDEAD00, 0);
    chk(overflow === 1, "R6 overflow set", overflow, 1);
    step(0, '0, 1);
    chk(full === 1, "R5 half-read word keeps slot", full, 1);
    step(1, 24'hBAD0BA, 1);  // write while full with a read in the same cycle
    chk(full === 0, "R5 slot freed after high half", full, 0);
    chk(rd_data === 12'h101, "R6 discarded write skipped", rd_data, 12'h101);
    for (int i = 0; i < 40; i++) step(0, '0, 1);
    chk(overflow === 1, "R6 overflow sticky", overflow, 1);

    // R9 reset mid-stream
    for (int i = 0; i < 5; i++) step(1, 24'($urandom), 0);
    step(0, '0, 1);
    do_reset();
    chk(empty === 1 && overflow === 0, "R9 reset clears", {empty, overflow}, 2'b10);

    // R10 sustained half-rate writes with the consumer always ready
    for (int i = 0; i < 400; i++) begin
      step(i % 2 == 0, 24'($urandom), 1);
      chk(full === 0 && overflow === 0, "R10 no full or overflow", {full, overflow}, 0);
    end
    for (int i = 0; i < 4; i++) step(0, '0, 1);
    chk(empty === 1, "R10 every sample delivered", empty, 1);

    // Random mix with stalls, hitting full with half-read head words
    for (int i = 0; i < 6000; i++) begin
      int p = (i / 500) % 3;
      step(($urandom % 100) < (p == 0 ? 30 : (p == 1 ? 60 : 85)), 24'($urandom),
           ($urandom % 100) < (p == 2 ? 40 : 75));
    end
    for (int i = 0; i < 2 * DEPTH + 2; i++) step(0, '0, 1);
    chk(empty === 1, "R3 random drain complete", empty, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule